// File: doc/BRIEF.md
# Snooping Cache Line Coherence State Controller

This block keeps the coherence state of every line of one cache that shares a snooping bus with other caches. Each cycle it may take one request from the local processor side (read, write or evict of a line index) and one observed transaction from another cache on the bus (a read, or a write / read-for-ownership) against a line index. From the line's current state it works out, in the same cycle, the bus action the local request needs and the response this cache owes the snooped transaction. The new state is registered on the next clock edge.

A fill on a local read miss uses the bus shared-line input, sampled with the request, to decide whether the line arrives exclusive or shared. For each snooped transaction the block also drives a hit output, which the bus combines into the shared-line signal that other caches see. The parameter `MODE` selects the full five-state protocol (2), a four-state subset without the owner state (1), or a three-state subset with neither the owner nor the shared state (0). Line data and bus arbitration belong to neighbouring blocks.

States: Invalid (no usable data), Shared (valid, other caches may hold copies), Exclusive (valid, clean, no other copy), Owned (valid, other caches may hold shared copies, memory stale, this cache answers for the data), Modified (valid, only copy, memory stale). Transitions: fill-exclusive, fill-shared, upgrade, silent-upgrade, write-allocate, evict-dirty, evict-clean, snoop-share, snoop-own, snoop-downgrade, snoop-kill.

Top module: `moesi_line_ctrl`

## Requirements
- R1: State codes are Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. Reset leaves every line Invalid. With MODE=1 no line ever holds Owned, and with MODE=0 no line ever holds Owned or Shared. `lcl_state` shows the registered state of line `lcl_idx` before the current cycle's events.
- R2: A local write (lcl_op=1) on an Invalid line issues read-for-ownership (lcl_bus_act=2). On a Shared or Owned line it issues invalidate (3). On an Exclusive line it issues nothing (0). On a Modified line it issues nothing. In every case the line is Modified afterwards.
- R3: A local read (lcl_op=0) on an Invalid line issues a read (lcl_bus_act=1). The line fills as Shared when `lcl_shared_in` is high and MODE is not 0, and as Exclusive otherwise. A read of any valid line issues nothing and leaves the state unchanged.
- R4: A local evict (lcl_op=2) on a Modified or Owned line issues a writeback (lcl_bus_act=4). An evict on an Exclusive or Shared line issues nothing. In both cases the line is Invalid afterwards. An evict on an Invalid line does nothing.
- R5: A snooped read (snp_is_write=0) of a Modified line responds with supply (snp_resp=1) and moves to Owned when MODE=2. When MODE=1 it responds with writeback (snp_resp=2) and moves to Shared. When MODE=0 it responds with writeback and moves to Invalid.
- R6: A snooped read of an Owned line responds with supply and stays Owned. A snooped read of an Exclusive line gives no response and moves to Shared, or to Invalid when MODE=0. A snooped read of a Shared or Invalid line changes nothing and gives no response.
- R7: A snooped write (snp_is_write=1) of a Modified or Owned line responds with supply and moves the line to Invalid. A snooped write of an Exclusive or Shared line moves it to Invalid with no response.
- R8: `snp_hit` is high exactly when a snooped transaction is present and its line was not Invalid before the cycle.
- R9: When a snoop and a local request name the same line in one cycle, the snoop transition is applied first. The local action and transition are then computed from the state the snoop leaves.
- R10: lcl_op=3, or lcl_valid low, has no effect on any line and drives lcl_bus_act=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present |
| lcl_op | input | 2 | 0 read, 1 write, 2 evict, 3 none |
| lcl_idx | input | clog2(LINES) | Line of the local request |
| lcl_shared_in | input | 1 | Bus shared-line response for a fill |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_is_write | input | 1 | 1 write or read-for-ownership, 0 read |
| snp_idx | input | clog2(LINES) | Line of the snooped transaction |
| lcl_bus_act | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| lcl_state | output | 3 | Registered state of line lcl_idx |
| snp_resp | output | 2 | 0 none, 1 supply, 2 writeback |
| snp_hit | output | 1 | Snooped line held valid |

## Verification
On every cycle, the assertions check several properties. The mode subsets hold. Writes always leave the line Modified and evictions always leave it Invalid. A snooped write without a local collision always clears the line. A supply response only comes from a Modified or Owned line, and read-for-ownership is only issued from Invalid. The exact action codes for every state, operation and mode come from the bench's reference model, which runs the same random and directed traffic in all three modes at once. Only that model shows the same-line collision ordering and the choice between exclusive and shared fills.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4
    } coh_state_e;

    typedef enum logic [1:0] {
        LOP_READ = 2'd0, LOP_WRITE = 2'd1, LOP_EVICT = 2'd2, LOP_NOP = 2'd3
    } lcl_op_e;

    typedef enum logic [2:0] {
        BA_NONE = 3'd0, BA_READ = 3'd1, BA_RFO = 3'd2, BA_INVAL = 3'd3, BA_WBACK = 3'd4
    } bus_act_e;

    typedef enum logic [1:0] {
        SR_NONE = 2'd0, SR_SUPPLY = 2'd1, SR_WBACK = 2'd2
    } snp_resp_e;

    localparam int MODE_MEI   = 0;
    localparam int MODE_MESI  = 1;
    localparam int MODE_MOESI = 2;
endpackage

// File: rtl/coh_state_store.sv
module coh_state_store #(
    parameter int LINES = 16,
    localparam int IW = $clog2(LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snp_we,
    input  logic [IW-1:0]          snp_idx,
    input  logic [2:0]             snp_nxt,
    input  logic                   lcl_we,
    input  logic [IW-1:0]          lcl_idx,
    input  logic [2:0]             lcl_nxt,
    output logic [2:0]             snp_cur,
    output logic [2:0]             lcl_cur,
    output logic [LINES-1:0][2:0]  st_flat
);
    logic [LINES-1:0][2:0] st_q;

    // state register: the local write lands last so it wins on a shared index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            if (snp_we) st_q[snp_idx] <= snp_nxt;
            if (lcl_we) st_q[lcl_idx] <= lcl_nxt;
        end
    end

    assign snp_cur = st_q[snp_idx];
    assign lcl_cur = st_q[lcl_idx];
    assign st_flat = st_q;
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
    import coh_pkg::*;
#(
    parameter int MODE = MODE_MOESI
) (
    input  logic       valid,
    input  logic       is_write,
    input  coh_state_e cur,
    output coh_state_e nxt,
    output snp_resp_e  resp,
    output logic       hit
);
    always_comb begin
        nxt  = cur;
        resp = SR_NONE;
        hit  = valid && (cur != ST_I);
        if (valid) begin
            if (is_write) begin
                unique case (cur)
                    ST_M, ST_O: begin resp = SR_SUPPLY; nxt = ST_I; end  // snoop-kill, dirty
                    ST_E, ST_S: nxt = ST_I;                             // snoop-kill, clean
                    default:    nxt = cur;
                endcase
            end else begin
                unique case (cur)
                    ST_M: begin
                        if (MODE == MODE_MOESI) begin
                            resp = SR_SUPPLY; nxt = ST_O;               // snoop-own
                        end else if (MODE == MODE_MESI) begin
                            resp = SR_WBACK;  nxt = ST_S;               // snoop-share
                        end else begin
                            resp = SR_WBACK;  nxt = ST_I;
                        end
                    end
                    ST_O: resp = SR_SUPPLY;
                    ST_E: nxt = (MODE == MODE_MEI) ? ST_I : ST_S;       // snoop-downgrade
                    default: nxt = cur;
                endcase
            end
        end
    end
endmodule

// File: rtl/coh_local_fsm.sv
module coh_local_fsm
    import coh_pkg::*;
#(
    parameter int MODE = MODE_MOESI
) (
    input  logic       valid,
    input  lcl_op_e    op,
    input  logic       shared_in,
    input  coh_state_e cur,
    output coh_state_e nxt,
    output bus_act_e   act
);
    always_comb begin
        nxt = cur;
        act = BA_NONE;
        if (valid) begin
            unique case (op)
                LOP_READ: begin
                    if (cur == ST_I) begin
                        act = BA_READ;                                  // fill-exclusive / fill-shared
                        nxt = (shared_in && MODE != MODE_MEI) ? ST_S : ST_E;
                    end
                end
                LOP_WRITE: begin
                    nxt = ST_M;
                    unique case (cur)
                        ST_I:       act = BA_RFO;                       // write-allocate
                        ST_S, ST_O: act = BA_INVAL;                     // upgrade
                        default:    act = BA_NONE;                      // silent-upgrade, or already M
                    endcase
                end
                LOP_EVICT: begin
                    unique case (cur)
                        ST_M, ST_O: begin act = BA_WBACK; nxt = ST_I; end  // evict-dirty
                        ST_E, ST_S: nxt = ST_I;                            // evict-clean
                        default:    nxt = cur;
                    endcase
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 16,
    parameter int MODE  = MODE_MOESI
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lcl_valid,
    input  logic [1:0]               lcl_op,
    input  logic [$clog2(LINES)-1:0] lcl_idx,
    input  logic                     lcl_shared_in,
    input  logic                     snp_valid,
    input  logic                     snp_is_write,
    input  logic [$clog2(LINES)-1:0] snp_idx,
    output logic [2:0]               lcl_bus_act,
    output logic [2:0]               lcl_state,
    output logic [1:0]               snp_resp,
    output logic                     snp_hit
);
    localparam int IW = $clog2(LINES);

    logic [2:0]            snp_cur_raw, lcl_cur_raw;
    logic [LINES-1:0][2:0] st_flat;
    coh_state_e            snp_nxt, lcl_eff, lcl_nxt;
    snp_resp_e             snp_resp_e_w;
    bus_act_e              lcl_act_e_w;
    logic                  same_line;

    coh_state_store #(.LINES(LINES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .snp_we  (snp_valid),
        .snp_idx (snp_idx),
        .snp_nxt (snp_nxt),
        .lcl_we  (lcl_valid),
        .lcl_idx (lcl_idx),
        .lcl_nxt (lcl_nxt),
        .snp_cur (snp_cur_raw),
        .lcl_cur (lcl_cur_raw),
        .st_flat (st_flat)
    );

    coh_snoop_fsm #(.MODE(MODE)) u_snoop (
        .valid    (snp_valid),
        .is_write (snp_is_write),
        .cur      (coh_state_e'(snp_cur_raw)),
        .nxt      (snp_nxt),
        .resp     (snp_resp_e_w),
        .hit      (snp_hit)
    );

    // snoop goes first on a shared index
    assign same_line = snp_valid && (snp_idx == lcl_idx);
    assign lcl_eff   = same_line ? snp_nxt : coh_state_e'(lcl_cur_raw);

    coh_local_fsm #(.MODE(MODE)) u_local (
        .valid     (lcl_valid),
        .op        (lcl_op_e'(lcl_op)),
        .shared_in (lcl_shared_in),
        .cur       (lcl_eff),
        .nxt       (lcl_nxt),
        .act       (lcl_act_e_w)
    );

    // output process
    always_comb begin
        lcl_bus_act = lcl_act_e_w;
        snp_resp    = snp_resp_e_w;
        lcl_state   = lcl_cur_raw;
    end
endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
    parameter int LINES = 16,
    parameter int MODE  = 2,
    localparam int IW = $clog2(LINES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lcl_valid,
    input logic [1:0]             lcl_op,
    input logic [IW-1:0]          lcl_idx,
    input logic                   snp_valid,
    input logic                   snp_is_write,
    input logic [IW-1:0]          snp_idx,
    input logic [2:0]             lcl_bus_act,
    input logic [2:0]             lcl_state,
    input logic [1:0]             snp_resp,
    input logic                   snp_hit,
    input logic [LINES-1:0][2:0]  st_flat
);
    a_r1_mode_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == 2) || (lcl_state != 3'd3 && (MODE == 1 || lcl_state != 3'd1)));

    a_r2_write_to_m: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_op == 2'd1) |=> st_flat[$past(lcl_idx)] == 3'd4);

    a_r2_rfo_only_from_i: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_bus_act == 3'd2 && !(snp_valid && snp_idx == lcl_idx)) |-> lcl_state == 3'd0);

    a_r4_evict_to_i: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_op == 2'd2) |=> st_flat[$past(lcl_idx)] == 3'd0);

    a_r7_snoop_write_to_i: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_is_write && !(lcl_valid && lcl_idx == snp_idx))
        |=> st_flat[$past(snp_idx)] == 3'd0);

    a_r7_supply_from_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_resp == 2'd1) |-> (st_flat[snp_idx] == 3'd4 || st_flat[snp_idx] == 3'd3));

    a_r8_hit_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |-> (snp_valid && st_flat[snp_idx] != 3'd0));
endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.LINES(LINES), .MODE(MODE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lcl_valid    (lcl_valid),
    .lcl_op       (lcl_op),
    .lcl_idx      (lcl_idx),
    .snp_valid    (snp_valid),
    .snp_is_write (snp_is_write),
    .snp_idx      (snp_idx),
    .lcl_bus_act  (lcl_bus_act),
    .lcl_state    (lcl_state),
    .snp_resp     (snp_resp),
    .snp_hit      (snp_hit),
    .st_flat      (st_flat)
);

// File: tb/tb_moesi_line_ctrl.sv
module tb_moesi_line_ctrl;
    localparam int LINES = 16;
    localparam int IW = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lv = 1'b0, sh = 1'b0, sv = 1'b0, sw = 1'b0;
    logic [1:0] op = 2'd3;
    logic [IW-1:0] li = '0, si = '0;

    logic [2:0] act_w [3];
    logic [2:0] st_w  [3];
    logic [1:0] rsp_w [3];
    logic       hit_w [3];

    int nchk = 0, nerr = 0;
    logic [2:0] mdl [3][LINES];

    always #5 clk = ~clk;

    moesi_line_ctrl #(.LINES(LINES), .MODE(2)) dut (
        .clk(clk), .rst_n(rst_n), .lcl_valid(lv), .lcl_op(op), .lcl_idx(li),
        .lcl_shared_in(sh), .snp_valid(sv), .snp_is_write(sw), .snp_idx(si),
        .lcl_bus_act(act_w[2]), .lcl_state(st_w[2]), .snp_resp(rsp_w[2]), .snp_hit(hit_w[2]));
    moesi_line_ctrl #(.LINES(LINES), .MODE(1)) dut_mesi (
        .clk(clk), .rst_n(rst_n), .lcl_valid(lv), .lcl_op(op), .lcl_idx(li),
        .lcl_shared_in(sh), .snp_valid(sv), .snp_is_write(sw), .snp_idx(si),
        .lcl_bus_act(act_w[1]), .lcl_state(st_w[1]), .snp_resp(rsp_w[1]), .snp_hit(hit_w[1]));
    moesi_line_ctrl #(.LINES(LINES), .MODE(0)) dut_mei (
        .clk(clk), .rst_n(rst_n), .lcl_valid(lv), .lcl_op(op), .lcl_idx(li),
        .lcl_shared_in(sh), .snp_valid(sv), .snp_is_write(sw), .snp_idx(si),
        .lcl_bus_act(act_w[0]), .lcl_state(st_w[0]), .snp_resp(rsp_w[0]), .snp_hit(hit_w[0]));

    // reference model built from the requirements (codes I0 S1 E2 O3 M4)
    function automatic logic [2:0] m_snp_next(int m, logic [2:0] s, logic w);
        if (w) return 3'd0;
        case (s)
            3'd4: return (m == 2) ? 3'd3 : (m == 1) ? 3'd1 : 3'd0;
            3'd2: return (m == 0) ? 3'd0 : 3'd1;
            default: return s;
        endcase
    endfunction

    function automatic logic [1:0] m_snp_rsp(int m, logic [2:0] s, logic w);
        if (w) return (s == 3'd4 || s == 3'd3) ? 2'd1 : 2'd0;
        if (s == 3'd3) return 2'd1;
        if (s == 3'd4) return (m == 2) ? 2'd1 : 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [2:0] m_lcl_next(int m, logic [2:0] s, logic [1:0] o, logic shr);
        case (o)
            2'd0: return (s == 3'd0) ? ((shr && m != 0) ? 3'd1 : 3'd2) : s;
            2'd1: return 3'd4;
            2'd2: return 3'd0;
            default: return s;
        endcase
    endfunction

    function automatic logic [2:0] m_lcl_act(logic [2:0] s, logic [1:0] o);
        case (o)
            2'd0: return (s == 3'd0) ? 3'd1 : 3'd0;
            2'd1: return (s == 3'd0) ? 3'd2 : (s == 3'd1 || s == 3'd3) ? 3'd3 : 3'd0;
            2'd2: return (s == 3'd4 || s == 3'd3) ? 3'd4 : 3'd0;
            default: return 3'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, int m, int actual, int expected);
        nchk++;
        if (actual != expected) begin
            nerr++;
            $display("FAIL %s mode%0d %s: actual %0d expected %0d", req, m, what, actual, expected);
        end
    endtask

    task automatic step(logic l_v, logic [1:0] l_op, logic [IW-1:0] l_i, logic l_sh,
                        logic s_v, logic s_w, logic [IW-1:0] s_i);
        @(negedge clk);
        lv = l_v; op = l_op; li = l_i; sh = l_sh; sv = s_v; sw = s_w; si = s_i;
        #1;
        for (int m = 0; m < 3; m++) begin
            logic [2:0] pre, sp, cur;
            string lreq;
            pre = mdl[m][l_i];
            sp  = mdl[m][s_i];
            cur = (s_v && s_i == l_i) ? m_snp_next(m, sp, s_w) : pre;
            if (s_v && l_v && s_i == l_i) lreq = "R9";
            else if (!l_v || l_op == 2'd3) lreq = "R10";
            else if (l_op == 2'd0) lreq = "R3";
            else if (l_op == 2'd1) lreq = "R2";
            else lreq = "R4";
            chk("R1", "lcl_state", m, st_w[m], pre);
            chk(lreq, "lcl_bus_act", m, act_w[m], l_v ? m_lcl_act(cur, l_op) : 3'd0);
            chk(s_w ? "R7" : "R5,R6", "snp_resp", m, rsp_w[m],
                s_v ? m_snp_rsp(m, sp, s_w) : 2'd0);
            chk("R8", "snp_hit", m, hit_w[m], (s_v && sp != 3'd0) ? 1 : 0);
            if (s_v) mdl[m][s_i] = m_snp_next(m, sp, s_w);
            if (l_v) mdl[m][l_i] = m_lcl_next(m, cur, l_op, l_sh);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #1000000;
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        for (int m = 0; m < 3; m++)
            for (int k = 0; k < LINES; k++) mdl[m][k] = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset: every line reads back Invalid, R10 idle query
        for (int k = 0; k < LINES; k++) step(1'b1, 2'd3, k[IW-1:0], 1'b0, 1'b0, 1'b0, '0);
        // R3 fill exclusive, R6 downgrade, R2 upgrade, R5 snoop of dirty, R2 from owner
        step(1, 2'd0, 4'd1, 0, 0, 0, 4'd0);
        step(0, 2'd0, 4'd0, 0, 1, 0, 4'd1);
        step(1, 2'd1, 4'd1, 0, 0, 0, 4'd0);
        step(0, 2'd0, 4'd0, 0, 1, 0, 4'd1);
        step(0, 2'd0, 4'd0, 0, 1, 0, 4'd1);
        step(1, 2'd1, 4'd1, 0, 0, 0, 4'd0);
        step(1, 2'd2, 4'd1, 0, 0, 0, 4'd0);   // R4 dirty evict
        step(1, 2'd0, 4'd2, 1, 0, 0, 4'd0);   // R3 fill shared
        step(1, 2'd1, 4'd2, 0, 0, 0, 4'd0);
        step(1, 2'd1, 4'd2, 0, 1, 1, 4'd2);   // R9 collision, snoop write then write
        step(1, 2'd0, 4'd3, 0, 1, 1, 4'd3);   // R9 collision on an Invalid line
        step(1, 2'd1, 4'd5, 0, 1, 1, 4'd2);   // R7 snoop write of Modified
        step(1, 2'd3, 4'd2, 0, 0, 0, 4'd0);   // R10 no-op leaves line alone
        for (int n = 0; n < 4000; n++) begin
            logic [IW-1:0] a, b;
            a = ($urandom % 2) ? IW'($urandom % 4) : IW'($urandom);
            b = ($urandom % 2) ? IW'($urandom % 4) : IW'($urandom);
            step(1'($urandom % 4 != 0), 2'($urandom), a, 1'($urandom),
                 1'($urandom % 3 == 0), 1'($urandom), b);
        end
        finish_run();
    end
endmodule